// File: doc/BRIEF.md
# Watchdog APB Register Bank

This block is the software-facing side of a multi-instance watchdog. It is an APB3 slave with a 12-bit address and 32-bit data that answers every transfer in its access phase with no wait states. At the bottom of the map it returns two fixed identification words and one word that describes how the block was built. Above them it holds one register set per watchdog instance, with a fixed stride between instances.

Each instance set keeps the configuration that the counting core needs: enable, a lock bit that can only be set once, the prescaler reload, the timeout reload and the lower window threshold. It also keeps the interrupt mask and the pending flags. The pending flags are set by event pulses from the core and cleared by software writing ones. A write to the kick offset does not store anything; it sends a one-cycle strobe to the core. The counter and the merging of interrupts live outside this block.

Once an instance is locked, its three reload values stop changing and its enable can only be set, not cleared. Mask, pending and kick writes still work, so an armed watchdog can still be serviced.

Top module: `wdog_apb_regs`

## Requirements
- R1: Offset 0x000 reads 0x00080015 and offset 0x004 reads 0x01000000.
- R2: Offset 0x008 reads the build word. Bits 7:0 hold the instance count, bits 15:8 the counter width, bits 23:16 the prescaler width, bit 24 the window option and bit 25 the lock option; all other bits read 0.
- R3: Instance n starts at 0x00C + 32·n. Its registers sit at these word offsets: control +0x00, prescaler +0x04, timeout +0x08, window +0x0C, status +0x10, pending +0x14, mask +0x18, kick +0x1C. Accesses reach only that instance.
- R4: After reset, prescaler and timeout are all ones. Control, window, pending and mask are 0.
- R5: Control bit 1 is the lock. Writing 1 sets it, and nothing but reset clears it. Control bit 0 is enable.
- R6: While an instance is locked, writes to its prescaler, timeout and window are dropped, and a control write with bit 0 = 0 leaves enable set. A control write with bit 0 = 1 still sets enable.
- R7: Any write to the kick offset drives that instance's kick_pulse bit high for exactly the one cycle after the access edge. The kick offset reads 0.
- R8: The status word reads {in_window (bit 2), lock (bit 1), enable (bit 0)}.
- R9: A timeout event pulse sets pending bits 0 and 1, and a violation event pulse sets bits 2 and 3. Writing 1 to a pending bit clears it. If an event and a clearing write arrive in the same cycle, the event wins.
- R10: The mask holds the low 4 bits written to it (2 bits without the window option), reads back, and drives irq_mask.
- R11: pready is always 1 and pslverr is always 0. Unmapped addresses read 0 and ignore writes.
- R12: The cfg_* outputs, irq_pending and irq_mask always show each instance's stored values, in fields of fixed width packed by instance index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| evt_timeout | input | NUM_DOGS | Timeout event pulse from each core |
| evt_violation | input | NUM_DOGS | Window violation pulse from each core |
| in_window | input | NUM_DOGS | Core reports counter inside kick window |
| cfg_enable | output | NUM_DOGS | Enable per instance |
| cfg_lock | output | NUM_DOGS | Lock per instance |
| cfg_prescale | output | NUM_DOGS·PRE_W | Prescaler reloads |
| cfg_reload | output | NUM_DOGS·CNT_W | Timeout reloads |
| cfg_window | output | NUM_DOGS·CNT_W | Window thresholds |
| irq_mask | output | NUM_DOGS·IRQ_N | Interrupt masks |
| irq_pending | output | NUM_DOGS·IRQ_N | Pending flags |
| kick_pulse | output | NUM_DOGS | One-cycle kick strobes |

## Verification
The pending flags can be cleared by software and set by a core event in the same clock. The bench provokes this by raising a timeout or violation pulse during the access phase of a write-one-to-clear to the same instance. It then judges the result by reading the flags back: set bits must survive, and only the cleared bits that had no event may drop. The lock write and a disable request can also arrive together in one control word. The bench checks that the lock state before the write decides whether the disable is honoured.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

  localparam logic [11:0] INST_BASE = 12'h00C;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_PRESC  = 3'd1,
    REG_RELOAD = 3'd2,
    REG_WIN    = 3'd3,
    REG_STAT   = 3'd4,
    REG_PEND   = 3'd5,
    REG_MASK   = 3'd6,
    REG_KICK   = 3'd7
  } reg_sel_e;

  localparam logic [31:0] ID_WORD0 = {8'h00, 8'h08, 16'h0015};
  localparam logic [31:0] ID_WORD1 = {8'h01, 8'h00, 16'h0000};

  // Build-description word: count, widths and option flags.
  function automatic logic [31:0] info_word(int n, int cw, int pw, bit win, bit lck);
    info_word = {6'd0, lck, win, 8'(pw), 8'(cw), 8'(n)};
  endfunction

  // Which of the four pending/mask bits exist for a given build.
  function automatic logic [3:0] irq_valid(bit win);
    irq_valid = win ? 4'hF : 4'h3;
  endfunction

  // Next pending value: W1C first, events override.
  function automatic logic [3:0] pend_step(logic [3:0] cur, logic [3:0] clr,
                                           logic to, logic vi, bit win);
    logic [3:0] set;
    set = {vi, vi, to, to} & irq_valid(win);
    pend_step = (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/wdr_addr_dec.sv
module wdr_addr_dec
  import wdr_pkg::*;
#(
  parameter int NUM_DOGS = 2,
  localparam int IDX_W = (NUM_DOGS > 1) ? $clog2(NUM_DOGS) : 1
) (
  input  logic [11:0]      addr,
  output logic             id0_hit,
  output logic             id1_hit,
  output logic             info_hit,
  output logic             inst_hit,
  output logic [IDX_W-1:0] inst_idx,
  output reg_sel_e         reg_sel
);
  logic [11:0] rel;
  logic        unused_lsb;

  assign unused_lsb = ^{addr[1:0], rel[1:0]};

  always_comb begin
    rel      = addr - INST_BASE;
    id0_hit  = (addr[11:2] == 10'd0);
    id1_hit  = (addr[11:2] == 10'd1);
    info_hit = (addr[11:2] == 10'd2);
    inst_hit = (addr >= INST_BASE) && (32'(rel[11:5]) < NUM_DOGS);
    inst_idx = rel[IDX_W+4:5];
    reg_sel  = reg_sel_e'(rel[4:2]);
  end
endmodule

// File: rtl/wdr_inst_regs.sv
module wdr_inst_regs
  import wdr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRE_W    = 16,
  parameter bit HAS_WIN  = 1'b1,
  parameter bit HAS_LOCK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         reg_sel,
  input  logic [31:0]      wdata,
  input  logic             evt_timeout,
  input  logic             evt_violation,
  input  logic             in_window_i,
  output logic             enable_o,
  output logic             lock_o,
  output logic [PRE_W-1:0] prescale_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] window_o,
  output logic [3:0]       mask_o,
  output logic [3:0]       pend_o,
  output logic             kick_o,
  output logic [31:0]      rdata
);
  logic             en_q, lock_q, kick_q;
  logic [PRE_W-1:0] presc_q;
  logic [CNT_W-1:0] reload_q, win_q;
  logic [3:0]       mask_q, pend_q;
  logic             wr_ctrl, wr_presc, wr_reload, wr_win, wr_pend, wr_mask, wr_kick;
  logic             in_eff;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;

  // Named write strobes for the assertions.
  assign wr_ctrl   = wr_en && (reg_sel == REG_CTRL);
  assign wr_presc  = wr_en && (reg_sel == REG_PRESC);
  assign wr_reload = wr_en && (reg_sel == REG_RELOAD);
  assign wr_win    = wr_en && (reg_sel == REG_WIN);
  assign wr_pend   = wr_en && (reg_sel == REG_PEND);
  assign wr_mask   = wr_en && (reg_sel == REG_MASK);
  assign wr_kick   = wr_en && (reg_sel == REG_KICK);
  assign in_eff    = HAS_WIN ? in_window_i : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      presc_q  <= '1;
      reload_q <= '1;
      mask_q   <= '0;
      pend_q   <= '0;
      kick_q   <= 1'b0;
    end else begin
      kick_q <= wr_kick;
      // Disable is refused only if the lock was already set before this write.
      if (wr_ctrl && (wdata[0] || !lock_q)) en_q <= wdata[0];
      if (!lock_q && wr_presc)  presc_q  <= wdata[PRE_W-1:0];
      if (!lock_q && wr_reload) reload_q <= wdata[CNT_W-1:0];
      if (wr_mask) mask_q <= wdata[3:0] & irq_valid(HAS_WIN);
      pend_q <= pend_step(pend_q, wr_pend ? wdata[3:0] : 4'd0,
                          evt_timeout, evt_violation, HAS_WIN);
    end
  end

  if (HAS_LOCK) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lock_q <= 1'b0;
      else if (wr_ctrl) lock_q <= lock_q | wdata[1];
    end
  end else begin : g_nolock
    assign lock_q = 1'b0;
  end

  if (HAS_WIN) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 win_q <= '0;
      else if (wr_win && !lock_q) win_q <= wdata[CNT_W-1:0];
    end
  end else begin : g_nowin
    assign win_q = '0;
  end

  always_comb begin
    case (reg_sel)
      REG_CTRL:   rdata = {30'd0, lock_q, en_q};
      REG_PRESC:  rdata = 32'(presc_q);
      REG_RELOAD: rdata = 32'(reload_q);
      REG_WIN:    rdata = 32'(win_q);
      REG_STAT:   rdata = {29'd0, in_eff, lock_q, en_q};
      REG_PEND:   rdata = {28'd0, pend_q};
      REG_MASK:   rdata = {28'd0, mask_q};
      default:    rdata = 32'd0;
    endcase
  end

  assign enable_o   = en_q;
  assign lock_o     = lock_q;
  assign prescale_o = presc_q;
  assign reload_o   = reload_q;
  assign window_o   = win_q;
  assign mask_o     = mask_q;
  assign pend_o     = pend_q;
  assign kick_o     = kick_q;

  // R5: the lock never falls once set
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R6: locked reload values hold
  p_locked_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(presc_q) && $stable(reload_q) && $stable(win_q)));
  // R6: a locked, enabled instance stays enabled
  p_locked_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && en_q) |=> en_q);
  // R7: the kick strobe lasts a single cycle
  p_kick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |=> !kick_q);
  // R9: a timeout event always leaves both timeout flags set
  p_evt_sets_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |=> (pend_o[1:0] == 2'b11));
  // R9: a flag drops only under a clearing write
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && !(wr_pend && wdata[0])) |=> pend_q[0]);
endmodule

// File: rtl/wdog_apb_regs.sv
module wdog_apb_regs
  import wdr_pkg::*;
#(
  parameter int NUM_DOGS = 2,
  parameter int CNT_W    = 32,
  parameter int PRE_W    = 16,
  parameter bit HAS_WIN  = 1'b1,
  parameter bit HAS_LOCK = 1'b1,
  localparam int IRQ_N = HAS_WIN ? 4 : 2,
  localparam int IDX_W = (NUM_DOGS > 1) ? $clog2(NUM_DOGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [11:0]               paddr,
  input  logic [31:0]               pwdata,
  output logic [31:0]               prdata,
  output logic                      pready,
  output logic                      pslverr,
  input  logic [NUM_DOGS-1:0]       evt_timeout,
  input  logic [NUM_DOGS-1:0]       evt_violation,
  input  logic [NUM_DOGS-1:0]       in_window,
  output logic [NUM_DOGS-1:0]       cfg_enable,
  output logic [NUM_DOGS-1:0]       cfg_lock,
  output logic [NUM_DOGS*PRE_W-1:0] cfg_prescale,
  output logic [NUM_DOGS*CNT_W-1:0] cfg_reload,
  output logic [NUM_DOGS*CNT_W-1:0] cfg_window,
  output logic [NUM_DOGS*IRQ_N-1:0] irq_mask,
  output logic [NUM_DOGS*IRQ_N-1:0] irq_pending,
  output logic [NUM_DOGS-1:0]       kick_pulse
);
  logic             acc_wr;
  logic             id0_hit, id1_hit, info_hit, inst_hit, any_hit;
  logic [IDX_W-1:0] inst_idx;
  reg_sel_e         reg_sel;
  logic [31:0]      rd_arr [NUM_DOGS];

  assign acc_wr  = psel && penable && pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  wdr_addr_dec #(.NUM_DOGS(NUM_DOGS)) u_dec (
    .addr(paddr), .id0_hit(id0_hit), .id1_hit(id1_hit), .info_hit(info_hit),
    .inst_hit(inst_hit), .inst_idx(inst_idx), .reg_sel(reg_sel)
  );

  assign any_hit = id0_hit || id1_hit || info_hit || inst_hit;

  for (genvar i = 0; i < NUM_DOGS; i++) begin : g_dog
    logic [3:0] mask4, pend4;
    wdr_inst_regs #(
      .CNT_W(CNT_W), .PRE_W(PRE_W), .HAS_WIN(HAS_WIN), .HAS_LOCK(HAS_LOCK)
    ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(acc_wr && inst_hit && (32'(inst_idx) == i)),
      .reg_sel(reg_sel), .wdata(pwdata),
      .evt_timeout(evt_timeout[i]), .evt_violation(evt_violation[i]),
      .in_window_i(in_window[i]),
      .enable_o(cfg_enable[i]), .lock_o(cfg_lock[i]),
      .prescale_o(cfg_prescale[i*PRE_W +: PRE_W]),
      .reload_o(cfg_reload[i*CNT_W +: CNT_W]),
      .window_o(cfg_window[i*CNT_W +: CNT_W]),
      .mask_o(mask4), .pend_o(pend4),
      .kick_o(kick_pulse[i]), .rdata(rd_arr[i])
    );
    assign irq_mask[i*IRQ_N +: IRQ_N]    = mask4[IRQ_N-1:0];
    assign irq_pending[i*IRQ_N +: IRQ_N] = pend4[IRQ_N-1:0];
    if (IRQ_N < 4) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^{mask4[3:IRQ_N], pend4[3:IRQ_N]};
    end
  end

  always_comb begin
    prdata = 32'd0;
    if (psel) begin
      if (id0_hit)       prdata = ID_WORD0;
      else if (id1_hit)  prdata = ID_WORD1;
      else if (info_hit) prdata = info_word(NUM_DOGS, CNT_W, PRE_W, HAS_WIN, HAS_LOCK);
      else if (inst_hit) prdata = rd_arr[inst_idx];
    end
  end

  // R11: an address outside the map reads as zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !any_hit) |-> (prdata == 32'd0));
  // R7: a kick strobe follows only a write access
  p_kick_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_pulse != '0) |-> $past(acc_wr));
endmodule

// File: tb/wdog_apb_regs_test.sv
`timescale 1ns/1ps
module wdog_apb_regs_test;
  localparam int N = 2;
  localparam int CW = 32;
  localparam int PW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;
  logic [N-1:0] evt_timeout = '0, evt_violation = '0, in_window = '0;
  logic [N-1:0] cfg_enable, cfg_lock, kick_pulse;
  logic [N*PW-1:0] cfg_prescale;
  logic [N*CW-1:0] cfg_reload, cfg_window;
  logic [N*4-1:0] irq_mask, irq_pending;

  int checks = 0, failures = 0;
  logic [N-1:0] kick_seen;
  logic resp_bad = 1'b0;

  always #4 clk = ~clk;

  wdog_apb_regs uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .evt_timeout(evt_timeout), .evt_violation(evt_violation),
    .in_window(in_window), .cfg_enable(cfg_enable), .cfg_lock(cfg_lock),
    .cfg_prescale(cfg_prescale), .cfg_reload(cfg_reload), .cfg_window(cfg_window),
    .irq_mask(irq_mask), .irq_pending(irq_pending), .kick_pulse(kick_pulse)
  );

  function automatic logic [11:0] ra(int inst, int slot);
    return 12'(12 + inst * 32 + slot * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(logic [11:0] a, logic [31:0] d,
                           logic [N-1:0] to = '0, logic [N-1:0] vi = '0);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; evt_timeout = to; evt_violation = vi;
    #1 if (pready !== 1'b1 || pslverr !== 1'b0) resp_bad = 1'b1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    evt_timeout = '0; evt_violation = '0; kick_seen = kick_pulse;
  endtask

  task automatic apb_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    if (pready !== 1'b1 || pslverr !== 1'b0) resp_bad = 1'b1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic pulse_evt(logic [N-1:0] to, logic [N-1:0] vi);
    @(negedge clk); evt_timeout = to; evt_violation = vi;
    @(negedge clk); evt_timeout = '0; evt_violation = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    apb_read(ra(0, 1), d); chk("R4 prescaler reset", d, 32'h0000FFFF);
    apb_read(ra(1, 2), d); chk("R4 timeout reset", d, 32'hFFFFFFFF);
    apb_read(ra(0, 0), d); chk("R4 control reset", d, 0);
    apb_read(ra(0, 3), d); chk("R4 window reset", d, 0);
    apb_read(ra(1, 5), d); chk("R4 pending reset", d, 0);
    apb_read(ra(1, 6), d); chk("R4 mask reset", d, 0);
    chk("R12 reset outputs", {cfg_enable, cfg_lock, irq_mask, irq_pending}, 0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    apb_read(12'h000, d); chk("R1 id word 0", d, 32'h00080015);
    apb_read(12'h004, d); chk("R1 id word 1", d, 32'h01000000);
    apb_read(12'h008, d); chk("R2 build word", d, 32'h03102002);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    apb_write(ra(1, 1), 32'h00001234);
    apb_write(ra(1, 2), 32'hABCD0001);
    apb_write(ra(1, 3), 32'h00000077);
    apb_read(ra(1, 1), d); chk("R3 inst1 prescaler", d, 32'h1234);
    apb_read(ra(1, 2), d); chk("R3 inst1 timeout", d, 32'hABCD0001);
    apb_read(ra(1, 3), d); chk("R3 inst1 window", d, 32'h77);
    apb_read(ra(0, 1), d); chk("R3 inst0 untouched", d, 32'hFFFF);
    chk("R12 prescale out", {16'd0, cfg_prescale}, {16'd0, 16'h1234, 16'hFFFF});
    chk("R12 reload out", cfg_reload[63:32], 32'hABCD0001);
    chk("R12 window out", cfg_window[63:32], 32'h77);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    apb_write(12'h04C, 32'hFFFFFFFF);
    apb_write(12'hFFC, 32'hFFFFFFFF);
    apb_read(12'h04C, d); chk("R11 unmapped read 0x04C", d, 0);
    apb_read(12'hFFC, d); chk("R11 unmapped read 0xFFC", d, 0);
    apb_read(ra(1, 0), d); chk("R11 unmapped write ignored", d, 0);
    chk("R11 ready/no error", {31'd0, resp_bad}, 0);
  endtask

  task automatic t_kick();
    logic [31:0] d;
    apb_write(ra(0, 7), 32'h0);
    chk("R7 kick strobe inst0", {30'd0, kick_seen}, 32'b01);
    @(negedge clk); chk("R7 kick single cycle", {30'd0, kick_pulse}, 0);
    apb_write(ra(1, 7), 32'hDEADBEEF);
    chk("R7 kick strobe inst1", {30'd0, kick_seen}, 32'b10);
    apb_read(ra(1, 7), d); chk("R7 kick reads zero", d, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    in_window = 2'b01;
    apb_write(ra(0, 0), 32'h1);
    apb_read(ra(0, 4), d); chk("R8 status inst0", d, 32'h5);
    apb_read(ra(1, 4), d); chk("R8 status inst1", d, 32'h0);
    in_window = '0;
  endtask

  task automatic t_mask();
    logic [31:0] d;
    apb_write(ra(0, 6), 32'hFF);
    apb_write(ra(1, 6), 32'h5);
    apb_read(ra(0, 6), d); chk("R10 mask inst0", d, 32'hF);
    apb_read(ra(1, 6), d); chk("R10 mask inst1", d, 32'h5);
    chk("R10 mask output", {24'd0, irq_mask}, 32'h5F);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    pulse_evt(2'b01, 2'b10);
    apb_read(ra(0, 5), d); chk("R9 timeout sets 0,1", d, 32'h3);
    apb_read(ra(1, 5), d); chk("R9 violation sets 2,3", d, 32'hC);
    chk("R12 pending output", {24'd0, irq_pending}, 32'hC3);
    apb_write(ra(0, 5), 32'h1);
    apb_read(ra(0, 5), d); chk("R9 W1C bit 0", d, 32'h2);
    // event and clear in one cycle on instance 1
    apb_write(ra(1, 5), 32'hF, 2'b10, 2'b00);
    apb_read(ra(1, 5), d); chk("R9 event beats clear", d, 32'h3);
    apb_write(ra(1, 5), 32'h3, 2'b00, 2'b10);
    apb_read(ra(1, 5), d); chk("R9 violation beats clear", d, 32'hC);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    apb_write(ra(0, 0), 32'h3);
    apb_write(ra(0, 0), 32'h0);
    apb_read(ra(0, 0), d); chk("R6 disable dropped when locked", d, 32'h3);
    apb_write(ra(0, 1), 32'h5);
    apb_read(ra(0, 1), d); chk("R6 prescaler frozen", d, 32'hFFFF);
    apb_write(ra(1, 0), 32'h2);
    apb_read(ra(1, 0), d); chk("R5 lock without enable", d, 32'h2);
    apb_write(ra(1, 0), 32'h1);
    apb_read(ra(1, 0), d); chk("R6 enable accepted when locked", d, 32'h3);
    apb_write(ra(1, 0), 32'h0);
    apb_read(ra(1, 0), d); chk("R5 lock not clearable", d, 32'h3);
    apb_write(ra(1, 2), 32'h10);
    apb_write(ra(1, 3), 32'h20);
    apb_read(ra(1, 2), d); chk("R6 timeout frozen", d, 32'hABCD0001);
    apb_read(ra(1, 3), d); chk("R6 window frozen", d, 32'h77);
    chk("R12 lock outputs", {30'd0, cfg_lock}, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ident();
    t_layout();
    t_unmapped();
    t_kick();
    t_status();
    t_mask();
    t_pending();
    t_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule